// File: doc/BRIEF.md
# Remote Terminal Command Validator

This block sits behind the word decoder of a serial command/response bus terminal. It decides, for each decoded command word, whether this terminal has to act on it. The terminal's own 5-bit address comes with a parity bit. It is taken from hard-wired strap inputs once, just after reset, or it is written by the host through a load port when software addressing is selected. Every address that is loaded is parity-checked. An address that fails the check, or that equals the reserved all-ones broadcast value, leaves the terminal in an address-fault state. In that state the terminal validates no command at all.

Each error-free command is matched against the terminal's own address and against the broadcast address. An accepted command produces a one-cycle strobe, one clock after the command is presented. With the strobe come a broadcast flag, the transfer direction, the subaddress, a mode-command flag, and either the expected data length or the mode code. These fields hold their values until the next accepted command. Commands that are flagged as erroneous, or that carry a foreign address, are dropped without any output activity.

Top module: `rt_cmd_validator`

## Requirements
- R1: While reset is asserted and on the first cycle after it, cmd_ok_o, bcast_o, xmit_o, mode_o, subaddr_o and wcount_o are 0 and addr_fault_o is 1.
- R2: On the first rising clock edge after reset is released with sw_sel_i low, the strap address and parity are captured and checked, and addr_fault_o shows the result from the next cycle on. Later changes on the straps have no effect.
- R3: An address is valid only when the six bits {parity, address} contain an odd number of ones. With an even count, addr_fault_o is 1, so any single flipped strap bit gives a fault.
- R4: Address 31 (all ones) is never accepted as the terminal's own address, even when its parity is correct.
- R5: While addr_fault_o is 1, no command is validated (cmd_ok_o stays 0).
- R6: A command word is laid out from the MSB as address[15:11], transmit[10], subaddress[9:5], count[4:0]. When cmd_valid_i is high, cmd_err_i is low, there is no fault and the address field equals the own address, cmd_ok_o is 1 on the next cycle only, with bcast_o = 0.
- R7: A command with address field 31 that passes the same conditions is validated with bcast_o = 1.
- R8: A command with cmd_err_i high, or with any other address, produces no strobe, and all field outputs keep their previous values.
- R9: On a validated command, xmit_o equals bit 10 and subaddr_o equals bits 9:5.
- R10: For subaddresses 1 to 30, mode_o is 0 and wcount_o is the count field, except that a count of 0 gives 32.
- R11: For subaddress 0 or 31, mode_o is 1 and wcount_o is the raw 5-bit count field (the mode code), zero-extended.
- R12: With sw_sel_i high, a host_wr_i pulse loads host_addr_i and host_par_i, checked as in R3 and R4, and the result is visible from the next cycle. With sw_sel_i low, host_wr_i is ignored.
- R13: If sw_sel_i is high when reset is released, the straps are not loaded and addr_fault_o stays 1 until the first host load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_addr_i | input | 5 | Strapped terminal address |
| strap_par_i | input | 1 | Strapped address parity (odd) |
| sw_sel_i | input | 1 | 1 = address is loaded by host, 0 = from straps |
| host_wr_i | input | 1 | Host address load strobe |
| host_addr_i | input | 5 | Host-written address |
| host_par_i | input | 1 | Host-written parity (odd) |
| cmd_valid_i | input | 1 | Decoded command word present |
| cmd_word_i | input | 16 | Decoded command word |
| cmd_err_i | input | 1 | Decode or parity error on this word |
| cmd_ok_o | output | 1 | One-cycle validated-command strobe |
| bcast_o | output | 1 | Validated command was broadcast |
| xmit_o | output | 1 | Terminal must transmit (1) or receive (0) |
| subaddr_o | output | 5 | Subaddress of the validated command |
| wcount_o | output | 6 | Data length 1..32, or mode code for mode commands |
| mode_o | output | 1 | Validated command is a mode command |
| addr_fault_o | output | 1 | Own address missing or failed its check |

## Verification
The bench flips each strap bit of a good address in turn. A design that checks the wrong parity sense, or that skips the check, would then accept commands under a corrupt address. It also straps the all-ones address with correct parity, which a design without the reserved-value check would take as its own. Random command streams mix own, broadcast and foreign addresses with error-flagged words. These catch a design that answers foreign addresses, that does not flag broadcast, or that changes its field outputs on dropped words. Counts of 0 and subaddresses 0 and 31 are forced to expose a wrong 32-word conversion or a mode code treated as a length. Host loads are tried with and without software selection, and strap changes after the power-on capture, to catch a design that reloads its address at the wrong time.

// File: rtl/rtcv_pkg.sv
package rtcv_pkg;
  localparam int ADDR_W = 5;
  localparam int SA_W   = 5;
  localparam int WC_W   = 5;
  localparam int CMD_W  = ADDR_W + 1 + SA_W + WC_W;
  localparam int LEN_W  = WC_W + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              xmit;
    logic [SA_W-1:0]   sa;
    logic [WC_W-1:0]   wc;
  } cmd_t;

  // odd parity over {p, a} and not the broadcast value
  function automatic logic addr_good(input logic [ADDR_W-1:0] a, input logic p);
    return (^{p, a}) && (a != {ADDR_W{1'b1}});
  endfunction

  function automatic logic is_mode(input logic [SA_W-1:0] sa);
    return (sa == '0) || (sa == {SA_W{1'b1}});
  endfunction

  function automatic logic [LEN_W-1:0] field_len(input logic [SA_W-1:0] sa,
                                                 input logic [WC_W-1:0] wc);
    if (is_mode(sa))   return {1'b0, wc};
    else if (wc == '0) return {1'b1, {WC_W{1'b0}}};
    else               return {1'b0, wc};
  endfunction
endpackage

// File: rtl/rtcv_addr_reg.sv
module rtcv_addr_reg
  import rtcv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              strap_par,
  input  logic              sw_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_par,
  output logic [ADDR_W-1:0] own_addr,
  output logic              own_par,
  output logic              addr_ok
);
  logic init_done_q;
  logic strap_load_w;
  logic host_load_w;
  logic [ADDR_W-1:0] next_addr_w;
  logic next_par_w;

  assign strap_load_w = !init_done_q && !sw_sel;
  assign host_load_w  = sw_sel && host_wr;
  assign next_addr_w  = host_load_w ? host_addr : strap_addr;
  assign next_par_w   = host_load_w ? host_par  : strap_par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_done_q <= 1'b0;
      own_addr    <= '0;
      own_par     <= 1'b0;
      addr_ok     <= 1'b0;
    end else begin
      init_done_q <= 1'b1;
      if (strap_load_w || host_load_w) begin
        own_addr <= next_addr_w;
        own_par  <= next_par_w;
        addr_ok  <= addr_good(next_addr_w, next_par_w);
      end
    end
  end
endmodule

// File: rtl/rtcv_cmd_decode.sv
module rtcv_cmd_decode
  import rtcv_pkg::*;
(
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              cmd_err,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              addr_ok,
  output logic              accept,
  output logic              bcast,
  output logic              xmit,
  output logic [SA_W-1:0]   sa,
  output logic [LEN_W-1:0]  len,
  output logic              mode
);
  cmd_t f;
  logic hit_own, hit_bc;

  assign f       = cmd_t'(cmd_word);
  assign hit_own = (f.addr == own_addr);
  assign hit_bc  = (f.addr == {ADDR_W{1'b1}});
  assign accept  = cmd_valid && !cmd_err && addr_ok && (hit_own || hit_bc);
  assign bcast   = hit_bc;
  assign xmit    = f.xmit;
  assign sa      = f.sa;
  assign mode    = is_mode(f.sa);
  assign len     = field_len(f.sa, f.wc);
endmodule

// File: rtl/rt_cmd_validator.sv
module rt_cmd_validator
  import rtcv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] strap_addr_i,
  input  logic              strap_par_i,
  input  logic              sw_sel_i,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_par_i,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_word_i,
  input  logic              cmd_err_i,
  output logic              cmd_ok_o,
  output logic              bcast_o,
  output logic              xmit_o,
  output logic [SA_W-1:0]   subaddr_o,
  output logic [LEN_W-1:0]  wcount_o,
  output logic              mode_o,
  output logic              addr_fault_o
);
  logic [ADDR_W-1:0] own_addr_q;
  logic              own_par_q;
  logic              addr_ok_w;
  logic              accept_w, bcast_w, xmit_w, mode_w;
  logic [SA_W-1:0]   sa_w;
  logic [LEN_W-1:0]  len_w;

  rtcv_addr_reg u_addr (
    .clk(clk), .rst_n(rst_n),
    .strap_addr(strap_addr_i), .strap_par(strap_par_i),
    .sw_sel(sw_sel_i), .host_wr(host_wr_i),
    .host_addr(host_addr_i), .host_par(host_par_i),
    .own_addr(own_addr_q), .own_par(own_par_q), .addr_ok(addr_ok_w)
  );

  rtcv_cmd_decode u_dec (
    .cmd_valid(cmd_valid_i), .cmd_word(cmd_word_i), .cmd_err(cmd_err_i),
    .own_addr(own_addr_q), .addr_ok(addr_ok_w),
    .accept(accept_w), .bcast(bcast_w), .xmit(xmit_w),
    .sa(sa_w), .len(len_w), .mode(mode_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_ok_o  <= 1'b0;
      bcast_o   <= 1'b0;
      xmit_o    <= 1'b0;
      subaddr_o <= '0;
      wcount_o  <= '0;
      mode_o    <= 1'b0;
    end else begin
      cmd_ok_o <= accept_w;
      if (accept_w) begin
        bcast_o   <= bcast_w;
        xmit_o    <= xmit_w;
        subaddr_o <= sa_w;
        wcount_o  <= len_w;
        mode_o    <= mode_w;
      end
    end
  end

  assign addr_fault_o = !addr_ok_w;
endmodule

// File: rtl/rtcv_checker.sv
module rtcv_checker
  import rtcv_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid_i,
  input logic              cmd_err_i,
  input logic [CMD_W-1:0]  cmd_word_i,
  input logic              cmd_ok_o,
  input logic              bcast_o,
  input logic              xmit_o,
  input logic [SA_W-1:0]   subaddr_o,
  input logic [LEN_W-1:0]  wcount_o,
  input logic              mode_o,
  input logic [ADDR_W-1:0] own_addr_q,
  input logic              own_par_q,
  input logic              addr_ok_w
);
  p_parity_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ok_w |-> (^{own_par_q, own_addr_q}));

  p_no_bcast_own_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ok_w |-> (own_addr_q != {ADDR_W{1'b1}}));

  p_no_accept_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok_o |-> $past(addr_ok_w));

  p_err_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_err_i) |=> !cmd_ok_o);

  p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ok_o |-> ($stable(bcast_o) && $stable(xmit_o) && $stable(subaddr_o)
                   && $stable(wcount_o) && $stable(mode_o)));

  p_bcast_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok_o |-> (bcast_o == ($past(cmd_word_i[CMD_W-1 -: ADDR_W]) == {ADDR_W{1'b1}})));

  p_len_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok_o && !mode_o) |-> ((wcount_o != '0) && (wcount_o <= LEN_W'(32))));
endmodule

bind rt_cmd_validator rtcv_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .cmd_valid_i(cmd_valid_i), .cmd_err_i(cmd_err_i), .cmd_word_i(cmd_word_i),
  .cmd_ok_o(cmd_ok_o), .bcast_o(bcast_o), .xmit_o(xmit_o),
  .subaddr_o(subaddr_o), .wcount_o(wcount_o), .mode_o(mode_o),
  .own_addr_q(own_addr_q), .own_par_q(own_par_q), .addr_ok_w(addr_ok_w)
);

// File: tb/rt_cmd_validator_tb.sv
module rt_cmd_validator_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] strap_addr_i = '0;
  logic strap_par_i = 1'b0, sw_sel_i = 1'b0, host_wr_i = 1'b0;
  logic [4:0] host_addr_i = '0;
  logic host_par_i = 1'b0, cmd_valid_i = 1'b0, cmd_err_i = 1'b0;
  logic [15:0] cmd_word_i = '0;
  logic cmd_ok_o, bcast_o, xmit_o, mode_o, addr_fault_o;
  logic [4:0] subaddr_o;
  logic [5:0] wcount_o;

  int checks = 0, errors = 0;
  // bench model state
  int m_own; bit m_ok;
  int e_bc, e_x, e_sa, e_len, e_mode;

  always #4 clk = ~clk;

  rt_cmd_validator dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit par_ok(input int a, input int p);
    int ones = p;
    for (int i = 0; i < 5; i++) ones += (a >> i) & 1;
    return (ones % 2 == 1) && (a != 31);
  endfunction

  function automatic int exp_len(input int sa, input int wc);
    if (sa == 0 || sa == 31) return wc;
    return (wc == 0) ? 32 : wc;
  endfunction

  task automatic start(input int a, input int p, input bit sw);
    @(negedge clk);
    rst_n = 1'b0; sw_sel_i = sw; strap_addr_i = 5'(a); strap_par_i = p[0];
    repeat (2) @(negedge clk);
    chk("R1 fault in reset", addr_fault_o, 1);
    chk("R1 strobe in reset", cmd_ok_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    m_ok = sw ? 1'b0 : par_ok(a, p);
    m_own = a;
    e_bc = 0; e_x = 0; e_sa = 0; e_len = 0; e_mode = 0;
  endtask

  task automatic host_load(input int a, input int p);
    host_wr_i = 1'b1; host_addr_i = 5'(a); host_par_i = p[0];
    @(negedge clk);
    host_wr_i = 1'b0;
    if (sw_sel_i) begin m_ok = par_ok(a, p); m_own = a; end
  endtask

  task automatic send(input int a, input int x, input int sa, input int wc,
                      input bit err, input string req);
    bit acc;
    cmd_valid_i = 1'b1; cmd_err_i = err;
    cmd_word_i = {5'(a), 1'(x), 5'(sa), 5'(wc)};
    acc = !err && m_ok && (a == m_own || a == 31);
    if (acc) begin
      e_bc = (a == 31); e_x = x; e_sa = sa;
      e_len = exp_len(sa, wc); e_mode = (sa == 0 || sa == 31);
    end
    @(negedge clk);
    cmd_valid_i = 1'b0; cmd_err_i = 1'b0;
    chk({req, " strobe"}, cmd_ok_o, acc);
    chk({req, " R7 bcast"}, bcast_o, e_bc);
    chk({req, " R9 xmit"}, xmit_o, e_x);
    chk({req, " R9 subaddr"}, subaddr_o, e_sa);
    chk({req, " R10 R11 count"}, wcount_o, e_len);
    chk({req, " R11 mode"}, mode_o, e_mode);
    @(negedge clk);
    chk({req, " R6 one-cycle strobe"}, cmd_ok_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    // R1, R2: good strap 5 (00101, two ones, parity 1)
    start(5, 1, 1'b0);
    chk("R1 strobe after reset", cmd_ok_o, 0);
    chk("R1 count after reset", wcount_o, 0);
    chk("R2 strap captured", addr_fault_o, 0);
    send(5, 0, 3, 4, 0, "R6 own");
    send(31, 0, 2, 0, 0, "R7 bcast");
    send(6, 1, 2, 2, 0, "R8 foreign");
    send(5, 1, 7, 9, 1, "R8 err");
    send(5, 1, 1, 0, 0, "R10 zero count");
    send(5, 0, 0, 17, 0, "R11 sa0");
    send(5, 1, 31, 2, 0, "R11 sa31");
    send(5, 0, 30, 31, 0, "R10 sa30");
    // R2: strap change after init ignored
    strap_addr_i = 5'd9; strap_par_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 fault after strap change", addr_fault_o, 0);
    send(9, 0, 4, 4, 0, "R2 new strap ignored");
    send(5, 0, 4, 4, 0, "R2 old address kept");
    // R12: host write ignored without software select
    host_load(9, 1);
    chk("R12 ignored fault", addr_fault_o, 0);
    send(9, 1, 5, 5, 0, "R12 ignored host");
    send(5, 1, 5, 5, 0, "R12 strap still own");
    // R3: single bit flips of the straps
    for (int b = 0; b < 6; b++) begin
      int a = 5 ^ ((b < 5) ? (1 << b) : 0);
      int p = (b == 5) ? 0 : 1;
      start(a, p, 1'b0);
      chk("R3 single flip fault", addr_fault_o, 1);
      send(a, 0, 3, 3, 0, "R5 faulted own");
      send(31, 0, 3, 3, 0, "R5 faulted bcast");
    end
    // R4: reserved address with correct parity
    start(31, 0, 1'b0);
    chk("R4 reserved fault", addr_fault_o, 1);
    send(31, 0, 3, 3, 0, "R4 R5 reserved");
    // R13, R12: software addressing
    start(5, 1, 1'b1);
    chk("R13 fault until load", addr_fault_o, 1);
    send(5, 0, 3, 3, 0, "R13 strap unused");
    host_load(9, 0);
    chk("R12 bad host parity", addr_fault_o, 1);
    host_load(9, 1);
    chk("R12 host load ok", addr_fault_o, 0);
    send(9, 1, 12, 0, 0, "R12 host own");
    send(5, 1, 12, 1, 0, "R12 strap not own");
    // random mix
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 9);
      int a = (r < 4) ? m_own : (r < 6) ? 31 : $urandom_range(0, 31);
      send(a, $urandom_range(0, 1), $urandom_range(0, 31), $urandom_range(0, 31),
           ($urandom_range(0, 9) == 0), "R6 R8 random");
      if (n == 200) host_load($urandom_range(0, 30), $urandom_range(0, 1));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule